// File: doc/BRIEF.md
# Bank Command Sequencer

This block controls a single DRAM bank. It tracks whether the bank is precharged or holds an open row. From the request candidate that the scheduler presents, it works out the next command the bank needs: activate, precharge, read or write, or a read or write with auto-precharge. It also follows the power-state and refresh commands that the channel actually issues. From those it keeps a sleeping flag and a blocked flag, and a count of activates for refresh management.

The page policy is fixed when the block is elaborated. The open policy leaves rows open. The closed policy always closes them with auto-precharge. The two adaptive policies choose between plain and auto-precharge accesses from two lookahead hints: whether further same-direction requests are queued for this bank, and whether any of them hits the open row. Checking timing is not done here. A single `timing_ok` input gates the proposal.

There are two handshakes. The request side is valid/ready. The scheduler may change or withdraw the candidate in any cycle. A candidate is taken only in a cycle where `req_valid` and `req_ready` are both high. When `req_ready` is low, the candidate is simply not taken; the scheduler need not hold it. The command side is a proposal (`cmd_valid`, `cmd`, `cmd_row`). The issue feedback (`iss_valid`, `iss_cmd`) is its acceptance, and the block changes state only on that feedback.

Top module: `bank_cmd_fsm`

## Requirements
- R1: After reset the bank is precharged, with no request held. `sleeping` and `blocked` are low, `act_cnt` is 0, and `req_ready` is high.
- R2: Proposed commands are encoded as NOP=0, ACT=1, PRE=2, RD=3, WR=4, RDA=5, WRA=6. With a request present, a precharged bank proposes ACT under every policy, and `cmd_row` carries the request's row. An issued ACT (issue code 0) sets `is_active` and stores that row in `open_row` from the next cycle.
- R3: Issue codes are 1, 2 and 3 for precharge of one bank, same banks and all banks, and 6 and 7 for RDA and WRA. Any of these leaves the bank precharged with no request held (`busy` low).
- R4: An issued plain read (code 4) or write (code 5) drops the held request. The bank stays activated with the same `open_row`.
- R5: Issue codes 8, 9 and 10 (active power-down, precharged power-down, self-refresh entry) set `sleeping`. Codes 11 and 12 (power-down exits) clear it. A pulse on `blk_req` sets `blocked`. Refresh (13) and refresh management (14) clear both flags. While either flag is set, `cmd` is NOP, `cmd_valid` is low and `req_ready` is low.
- R6: Under the open, open-adaptive and closed-adaptive policies, an activated bank proposes PRE for a request to another row. Under the closed policy it proposes RDA or WRA.
- R7: On a row hit, the open policy proposes RD or WR. On an activated bank, the closed policy proposes RDA or WRA.
- R8: On a row hit, the open-adaptive policy proposes RDA or WRA only when `more_req` is high and `more_hit` is low. Otherwise it proposes RD or WR.
- R9: On a row hit, the closed-adaptive policy proposes RD or WR when `more_hit` is high. Otherwise it proposes RDA or WRA.
- R10: From an issued ACT until the request is retired, `req_ready` is low for a candidate to a different row. The proposal then stays on the held request and the open row.
- R11: An issued ACT increments `act_cnt`, saturating at its maximum. A refresh subtracts `ref_dec` and a refresh-management command subtracts `rfm_dec`, each saturating at zero.
- R12: `cmd_valid` is high only when `cmd` is not NOP and `timing_ok` is high.
- R13: `bank_group` equals bank index divided by banks per group. `bank_rank` equals bank index divided by banks per rank.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request candidate present |
| req_ready | output | 1 | Candidate can be taken this cycle |
| req_row | input | ROW_W | Candidate row |
| req_write | input | 1 | Candidate is a write (0 = read) |
| more_req | input | 1 | Further same-direction requests queued for this bank |
| more_hit | input | 1 | A further queued same-direction request hits the open row |
| timing_ok | input | 1 | External timing check allows the proposed command |
| blk_req | input | 1 | Block the bank until the next refresh |
| iss_valid | input | 1 | A command was issued to this bank |
| iss_cmd | input | 4 | Code of the issued command |
| ref_dec | input | CNT_W | Amount a refresh removes from the counter |
| rfm_dec | input | CNT_W | Amount a refresh-management command removes |
| cmd_valid | output | 1 | Proposal is ready to issue |
| cmd | output | 3 | Proposed command code |
| cmd_row | output | ROW_W | Row of the proposed command |
| open_row | output | ROW_W | Currently open row |
| is_active | output | 1 | Bank has a row open |
| busy | output | 1 | A request is held after its activate |
| sleeping | output | 1 | Bank is in power-down or self-refresh |
| blocked | output | 1 | Bank is blocked until refresh |
| act_cnt | output | CNT_W | Activation counter |
| bank_group | output | IDX_W | Bank group index |
| bank_rank | output | IDX_W | Rank index |

## Verification
The hardest case to reach is the held-request window. A row has been activated for a request, and a conflicting candidate then arrives before that request's access is issued. This window exists only between an issued ACT and the next issued access. The bench opens it by issuing ACT from the feedback port and then walking the hint table while the bank stays activated. It then presents a different row, and expects `req_ready` low and the proposal still pointing at the held row. All four policies are instantiated side by side and share one stimulus stream, so every hint combination is compared across the policies in the same cycle.

// File: rtl/bank_cmd_pkg.sv
package bank_cmd_pkg;

  typedef enum logic [2:0] {
    C_NOP = 3'd0, C_ACT = 3'd1, C_PRE = 3'd2, C_RD = 3'd3,
    C_WR  = 3'd4, C_RDA = 3'd5, C_WRA = 3'd6
  } prop_cmd_e;

  typedef enum logic [3:0] {
    I_ACT      = 4'd0,  I_PRE_ONE  = 4'd1,  I_PRE_SAME = 4'd2,
    I_PRE_ALL  = 4'd3,  I_RD       = 4'd4,  I_WR       = 4'd5,
    I_RDA      = 4'd6,  I_WRA      = 4'd7,  I_PDN_ACT  = 4'd8,
    I_PDN_PRE  = 4'd9,  I_SREF_IN  = 4'd10, I_PDX_ACT  = 4'd11,
    I_PDX_PRE  = 4'd12, I_REF      = 4'd13, I_RFM      = 4'd14,
    I_SPARE    = 4'd15
  } iss_cmd_e;

  typedef enum logic [1:0] {
    POL_OPEN, POL_CLOSED, POL_OPEN_ADAPT, POL_CLOSED_ADAPT
  } page_pol_e;

endpackage

// File: rtl/bank_track.sv
module bank_track
  import bank_cmd_pkg::*;
#(
  parameter int ROW_W = 14
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             iss_valid,
  input  iss_cmd_e         iss_cmd,
  input  logic             blk_req,
  input  logic             accept,
  input  logic             req_write,
  input  logic [ROW_W-1:0] eff_row,
  input  logic             eff_write,
  output logic             active,
  output logic [ROW_W-1:0] open_row,
  output logic             keep,
  output logic             cur_write,
  output logic             sleeping,
  output logic             blocked
);

  logic is_refresh;
  assign is_refresh = iss_valid && (iss_cmd == I_REF || iss_cmd == I_RFM);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active    <= 1'b0;
      open_row  <= '0;
      keep      <= 1'b0;
      cur_write <= 1'b0;
      sleeping  <= 1'b0;
      blocked   <= 1'b0;
    end else begin
      if (accept) cur_write <= req_write;
      if (blk_req && !is_refresh) blocked <= 1'b1;
      if (iss_valid) begin
        unique case (iss_cmd)
          I_ACT: begin
            active    <= 1'b1;
            open_row  <= eff_row;
            keep      <= 1'b1;
            cur_write <= eff_write;
          end
          I_PRE_ONE, I_PRE_SAME, I_PRE_ALL, I_RDA, I_WRA: begin
            active <= 1'b0;
            keep   <= 1'b0;
          end
          I_RD, I_WR: keep <= 1'b0;
          I_PDN_ACT, I_PDN_PRE, I_SREF_IN: sleeping <= 1'b1;
          I_PDX_ACT, I_PDX_PRE: sleeping <= 1'b0;
          I_REF, I_RFM: begin
            sleeping <= 1'b0;
            blocked  <= 1'b0;
          end
          default: ;
        endcase
      end
    end
  end

  p_act_opens_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_valid && iss_cmd == I_ACT) |=> (active && open_row == $past(eff_row)));

  p_close_retires_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_valid && (iss_cmd inside {I_PRE_ONE, I_PRE_SAME, I_PRE_ALL, I_RDA, I_WRA}))
    |=> (!active && !keep));

  p_plain_keeps_row_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_valid && (iss_cmd inside {I_RD, I_WR}) && active)
    |=> (active && !keep && $stable(open_row)));

  p_sleep_enter_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_valid && (iss_cmd inside {I_PDN_ACT, I_PDN_PRE, I_SREF_IN})) |=> sleeping);

endmodule

// File: rtl/bank_policy.sv
module bank_policy
  import bank_cmd_pkg::*;
#(
  parameter page_pol_e POLICY = POL_OPEN
) (
  input  logic      active,
  input  logic      hit,
  input  logic      wr,
  input  logic      more_req,
  input  logic      more_hit,
  output prop_cmd_e cmd_raw
);

  logic use_auto;

  always_comb begin
    unique case (POLICY)
      POL_OPEN:         use_auto = 1'b0;
      POL_CLOSED:       use_auto = 1'b1;
      POL_OPEN_ADAPT:   use_auto = more_req && !more_hit;
      POL_CLOSED_ADAPT: use_auto = !more_hit;
      default:          use_auto = 1'b0;
    endcase

    if (!active)
      cmd_raw = C_ACT;
    else if (!hit && POLICY != POL_CLOSED)
      cmd_raw = C_PRE;
    else if (use_auto)
      cmd_raw = wr ? C_WRA : C_RDA;
    else
      cmd_raw = wr ? C_WR : C_RD;
  end

endmodule

// File: rtl/bank_act_cnt.sv
module bank_act_cnt
  import bank_cmd_pkg::*;
#(
  parameter int CNT_W  = 8,
  parameter bit RFM_EN = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             iss_valid,
  input  iss_cmd_e         iss_cmd,
  input  logic [CNT_W-1:0] ref_dec,
  input  logic [CNT_W-1:0] rfm_dec,
  output logic [CNT_W-1:0] cnt
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  generate
    if (RFM_EN) begin : g_count
      logic [CNT_W-1:0] dec;
      assign dec = (iss_cmd == I_REF) ? ref_dec : rfm_dec;

      always_ff @(posedge clk) begin
        if (!rst_n) begin
          cnt <= '0;
        end else if (iss_valid) begin
          if (iss_cmd == I_ACT && cnt != CNT_MAX)
            cnt <= cnt + 1'b1;
          else if (iss_cmd == I_REF || iss_cmd == I_RFM)
            cnt <= (cnt > dec) ? cnt - dec : '0;
        end
      end

      p_act_incr_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (iss_valid && iss_cmd == I_ACT && cnt != CNT_MAX) |=> (cnt == $past(cnt) + 1'b1));

      p_ref_floor_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (iss_valid && iss_cmd == I_REF && cnt <= ref_dec) |=> (cnt == '0));
    end else begin : g_none
      assign cnt = '0;
    end
  endgenerate

endmodule

// File: rtl/bank_cmd_fsm.sv
module bank_cmd_fsm
  import bank_cmd_pkg::*;
#(
  parameter page_pol_e POLICY          = POL_OPEN,
  parameter int        ROW_W           = 14,
  parameter int        CNT_W           = 8,
  parameter int        IDX_W           = 4,
  parameter int        BANK_ID         = 5,
  parameter int        BANKS_PER_GROUP = 4,
  parameter int        BANKS_PER_RANK  = 16,
  parameter bit        RFM_EN          = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [ROW_W-1:0] req_row,
  input  logic             req_write,
  input  logic             more_req,
  input  logic             more_hit,
  input  logic             timing_ok,
  input  logic             blk_req,
  input  logic             iss_valid,
  input  logic [3:0]       iss_cmd,
  input  logic [CNT_W-1:0] ref_dec,
  input  logic [CNT_W-1:0] rfm_dec,
  output logic             cmd_valid,
  output logic [2:0]       cmd,
  output logic [ROW_W-1:0] cmd_row,
  output logic [ROW_W-1:0] open_row,
  output logic             is_active,
  output logic             busy,
  output logic             sleeping,
  output logic             blocked,
  output logic [CNT_W-1:0] act_cnt,
  output logic [IDX_W-1:0] bank_group,
  output logic [IDX_W-1:0] bank_rank
);

  localparam logic [IDX_W-1:0] GROUP_IDX = IDX_W'(BANK_ID / BANKS_PER_GROUP);
  localparam logic [IDX_W-1:0] RANK_IDX  = IDX_W'(BANK_ID / BANKS_PER_RANK);

  iss_cmd_e         iss_e;
  logic             gate, accept, eff_valid, eff_write, cur_write;
  logic [ROW_W-1:0] eff_row;
  prop_cmd_e        cmd_raw, cmd_e;

  assign iss_e      = iss_cmd_e'(iss_cmd);
  assign bank_group = GROUP_IDX;
  assign bank_rank  = RANK_IDX;

  assign gate      = sleeping || blocked;
  assign req_ready = !gate && (!busy || req_row == open_row);
  assign accept    = req_valid && req_ready;
  assign eff_valid = accept || busy;
  assign eff_row   = accept ? req_row : open_row;
  assign eff_write = accept ? req_write : cur_write;

  bank_track #(.ROW_W(ROW_W)) track_i (
    .clk(clk), .rst_n(rst_n), .iss_valid(iss_valid), .iss_cmd(iss_e),
    .blk_req(blk_req), .accept(accept), .req_write(req_write),
    .eff_row(eff_row), .eff_write(eff_write), .active(is_active),
    .open_row(open_row), .keep(busy), .cur_write(cur_write),
    .sleeping(sleeping), .blocked(blocked)
  );

  bank_policy #(.POLICY(POLICY)) policy_i (
    .active(is_active), .hit(eff_row == open_row), .wr(eff_write),
    .more_req(more_req), .more_hit(more_hit), .cmd_raw(cmd_raw)
  );

  bank_act_cnt #(.CNT_W(CNT_W), .RFM_EN(RFM_EN)) cnt_i (
    .clk(clk), .rst_n(rst_n), .iss_valid(iss_valid), .iss_cmd(iss_e),
    .ref_dec(ref_dec), .rfm_dec(rfm_dec), .cnt(act_cnt)
  );

  assign cmd_e     = (eff_valid && !gate) ? cmd_raw : C_NOP;
  assign cmd       = cmd_e;
  assign cmd_row   = eff_row;
  assign cmd_valid = (cmd_e != C_NOP) && timing_ok;

  p_gated_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (sleeping || blocked) |-> (!cmd_valid && !req_ready));

  p_timing_gate_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !timing_ok |-> !cmd_valid);

  p_closed_act_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !is_active) |-> (cmd == C_ACT));

  p_closed_auto_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (POLICY == POL_CLOSED && cmd_valid && is_active) |-> (cmd == C_RDA || cmd == C_WRA));

  p_held_row_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && req_row != open_row) |-> (!req_ready && cmd_row == open_row));

endmodule

// File: tb/bank_cmd_fsm_tb_top.sv
module bank_cmd_fsm_tb_top;
  import bank_cmd_pkg::*;

  localparam int ROW_W = 14;
  localparam int CNT_W = 8;
  localparam int IDX_W = 4;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic             rst_n, req_valid, req_write, more_req, more_hit;
  logic             timing_ok, blk_req, iss_valid;
  logic [ROW_W-1:0] req_row;
  logic [3:0]       iss_cmd;
  logic [CNT_W-1:0] ref_dec, rfm_dec;

  logic             rdy_w   [4];
  logic             cv_w    [4];
  logic [2:0]       cmd_w   [4];
  logic [ROW_W-1:0] crow_w  [4];
  logic [ROW_W-1:0] orow_w  [4];
  logic             act_w   [4];
  logic             busy_w  [4];
  logic             slp_w   [4];
  logic             blk_w   [4];
  logic [CNT_W-1:0] cnt_w   [4];
  logic [IDX_W-1:0] grp_w   [4];
  logic [IDX_W-1:0] rnk_w   [4];

  for (genvar k = 0; k < 4; k++) begin : g_dut
    bank_cmd_fsm #(.POLICY(page_pol_e'(k)), .ROW_W(ROW_W), .CNT_W(CNT_W),
                   .IDX_W(IDX_W), .BANK_ID(5), .BANKS_PER_GROUP(4),
                   .BANKS_PER_RANK(16)) dut_i (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(rdy_w[k]),
      .req_row(req_row), .req_write(req_write), .more_req(more_req),
      .more_hit(more_hit), .timing_ok(timing_ok), .blk_req(blk_req),
      .iss_valid(iss_valid), .iss_cmd(iss_cmd), .ref_dec(ref_dec),
      .rfm_dec(rfm_dec), .cmd_valid(cv_w[k]), .cmd(cmd_w[k]),
      .cmd_row(crow_w[k]), .open_row(orow_w[k]), .is_active(act_w[k]),
      .busy(busy_w[k]), .sleeping(slp_w[k]), .blocked(blk_w[k]),
      .act_cnt(cnt_w[k]), .bank_group(grp_w[k]), .bank_rank(rnk_w[k])
    );
  end

  // {write, more_req, more_hit, open, closed, open-adaptive, closed-adaptive}
  localparam logic [14:0] VEC [0:7] = '{
    {1'b1, 1'b0, 1'b0, 3'd4, 3'd6, 3'd4, 3'd6},
    {1'b1, 1'b1, 1'b0, 3'd4, 3'd6, 3'd6, 3'd6},
    {1'b1, 1'b0, 1'b1, 3'd4, 3'd6, 3'd4, 3'd4},
    {1'b1, 1'b1, 1'b1, 3'd4, 3'd6, 3'd4, 3'd4},
    {1'b0, 1'b0, 1'b0, 3'd3, 3'd5, 3'd3, 3'd5},
    {1'b0, 1'b1, 1'b0, 3'd3, 3'd5, 3'd5, 3'd5},
    {1'b0, 1'b0, 1'b1, 3'd3, 3'd5, 3'd3, 3'd3},
    {1'b0, 1'b1, 1'b1, 3'd3, 3'd5, 3'd3, 3'd3}
  };

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic chk_cmds(input string tag, input int e0, input int e1,
                          input int e2, input int e3);
    chk({tag, " open"},      int'(cmd_w[0]), e0);
    chk({tag, " closed"},    int'(cmd_w[1]), e1);
    chk({tag, " open-ad"},   int'(cmd_w[2]), e2);
    chk({tag, " closed-ad"}, int'(cmd_w[3]), e3);
  endtask

  // called just after a falling edge; effects are visible at the next one
  task automatic issue(input logic [3:0] code);
    iss_valid = 1'b1;
    iss_cmd   = code;
    @(negedge clk);
    iss_valid = 1'b0;
    #1;
  endtask

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0; more_req = 1'b0;
    more_hit = 1'b0; timing_ok = 1'b0; blk_req = 1'b0; iss_valid = 1'b0;
    req_row = '0; iss_cmd = '0; ref_dec = '0; rfm_dec = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;

    // R1 reset state
    chk("R1 is_active", int'(act_w[0]), 0);
    chk("R1 sleeping", int'(slp_w[0]), 0);
    chk("R1 blocked", int'(blk_w[0]), 0);
    chk("R1 act_cnt", int'(cnt_w[0]), 0);
    chk("R1 req_ready", int'(rdy_w[0]), 1);
    chk("R1 cmd_valid", int'(cv_w[0]), 0);
    // R13 indices: bank 5, 4 per group, 16 per rank
    chk("R13 bank_group", int'(grp_w[0]), 1);
    chk("R13 bank_rank", int'(rnk_w[0]), 0);

    // R12 timing gate, R2 activate proposal
    req_valid = 1'b1; req_row = 14'h12; req_write = 1'b0; #2;
    chk_cmds("R2 precharged", 1, 1, 1, 1);
    chk("R12 cmd_valid no timing", int'(cv_w[0]), 0);
    timing_ok = 1'b1; #2;
    chk("R12 cmd_valid timing", int'(cv_w[0]), 1);
    chk("R2 cmd_row", int'(crow_w[0]), 'h12);
    issue(4'd0);
    chk("R2 is_active", int'(act_w[0]), 1);
    chk("R2 open_row", int'(orow_w[0]), 'h12);
    chk("R10 busy after act", int'(busy_w[0]), 1);
    chk("R11 act_cnt 1", int'(cnt_w[0]), 1);

    // R7 R8 R9 policy table on a row hit
    for (int i = 0; i < 8; i++) begin
      req_write = VEC[i][14];
      more_req  = VEC[i][13];
      more_hit  = VEC[i][12];
      #2;
      chk_cmds($sformatf("R7/R8/R9 vec%0d", i), int'(VEC[i][11:9]),
               int'(VEC[i][8:6]), int'(VEC[i][5:3]), int'(VEC[i][2:0]));
      @(negedge clk); #1;
    end

    // R10 conflicting candidate while request is held
    more_req = 1'b0; more_hit = 1'b0;
    req_row = 14'h34; req_write = 1'b1; #2;
    chk("R10 req_ready conflict", int'(rdy_w[0]), 0);
    chk("R10 cmd_row held", int'(crow_w[0]), 'h12);
    chk_cmds("R10 held read", 3, 5, 3, 5);

    // R4 plain read retires, row stays open
    req_row = 14'h12; req_write = 1'b0;
    issue(4'd4);
    chk("R4 busy", int'(busy_w[0]), 0);
    chk("R4 is_active", int'(act_w[0]), 1);
    chk("R4 open_row", int'(orow_w[0]), 'h12);

    // R6 row miss
    req_row = 14'h34; #2;
    chk("R6 req_ready", int'(rdy_w[0]), 1);
    chk_cmds("R6 miss", 2, 5, 2, 2);

    // R3 same-bank precharge, then activate and write with auto-precharge
    issue(4'd2);
    chk("R3 pre same", int'(act_w[0]), 0);
    chk_cmds("R2 reopen", 1, 1, 1, 1);
    issue(4'd0);
    chk("R2 open_row 34", int'(orow_w[0]), 'h34);
    chk("R11 act_cnt 2", int'(cnt_w[0]), 2);
    req_write = 1'b1;
    issue(4'd7);
    chk("R3 wra active", int'(act_w[0]), 0);
    chk("R3 wra busy", int'(busy_w[0]), 0);

    // R5 sleep and block
    issue(4'd9);
    chk("R5 sleeping", int'(slp_w[0]), 1);
    chk("R5 sleep cmd", int'(cmd_w[0]), 0);
    chk("R5 sleep cmd_valid", int'(cv_w[0]), 0);
    chk("R5 sleep req_ready", int'(rdy_w[0]), 0);
    issue(4'd12);
    chk("R5 wake", int'(slp_w[0]), 0);
    chk("R5 wake cmd_valid", int'(cv_w[0]), 1);
    blk_req = 1'b1;
    @(negedge clk); #1;
    blk_req = 1'b0;
    chk("R5 blocked", int'(blk_w[0]), 1);
    chk("R5 blocked cmd_valid", int'(cv_w[0]), 0);
    ref_dec = 8'd1;
    issue(4'd13);
    chk("R5 refresh unblocks", int'(blk_w[0]), 0);
    chk("R11 refresh dec", int'(cnt_w[0]), 1);

    // R3 all-bank precharge, R5/R11 self-refresh then refresh management
    issue(4'd0);
    chk("R11 act_cnt again", int'(cnt_w[0]), 2);
    issue(4'd3);
    chk("R3 pre all", int'(act_w[0]), 0);
    issue(4'd10);
    chk("R5 self-refresh", int'(slp_w[0]), 1);
    rfm_dec = 8'd5;
    issue(4'd14);
    chk("R5 rfm wakes", int'(slp_w[0]), 0);
    chk("R11 rfm floor", int'(cnt_w[0]), 0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule